// File: doc/BRIEF.md
# Vector Lane Insert, Broadcast and Gather Unit

This unit moves single elements between two kinds of register group. The packed side holds one or two 64-bit registers whose elements are numbered consecutively from bit 0 upward. The per-lane side holds up to four 64-bit registers, each divided into lanes of the selected element width. Three operations are offered. Unpack writes packed element i into one chosen lane of per-lane register i and leaves every other lane alone. Unpack-all writes packed element i into every lane of per-lane register i. Pack reads one chosen lane from each per-lane register i and places it at packed element i.

Each operation is issued with a one-cycle start strobe together with the operation code, element width code, lane index, both register counts and the current contents of both register groups. The current contents act as the old destination values. One cycle later the unit presents both register groups as they should be written back, together with a valid pulse and an error flag. An illegal combination raises the error flag and returns both groups unchanged. Between strobes the result registers hold their value.

Top module: `lane_shuffle`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after a cycle in which `start_i` was sampled high. While `start_i` is low, `ln_res_o`, `pk_res_o` and `res_err_o` keep their values.
- R2: Unpack (`op_i` = 0): for each i below the lane-side count, lane `lane_i` of lane register i (bits i*64 + lane*W upward) takes packed element i (bits i*W upward of `pk_data_i`). All other lanes, and registers at or above the count, keep their `ln_data_i` contents.
- R3: Unpack-all (`op_i` = 1): for each i below the lane-side count, every lane of lane register i takes packed element i. Registers at or above the count keep their `ln_data_i` contents.
- R4: Pack (`op_i` = 2): packed element i takes lane `lane_i` of lane register i for i below the lane-side count. Remaining elements inside the first `pk_cnt_i` packed registers become zero. A packed register at or above `pk_cnt_i` keeps its `pk_data_i` contents.
- R5: `esz_i` selects the element width W: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. Each register holds 64/W lanes.
- R6: A lane index of 64/W or above raises `res_err_o`.
- R7: `res_err_o` is also raised when `op_i` = 3, `esz_i` = 3, `pk_cnt_i` is outside 1..2, `ln_cnt_i` is below `pk_cnt_i` or above 4, or `ln_cnt_i`*W exceeds `pk_cnt_i`*64.
- R8: When `res_err_o` is raised, `ln_res_o` equals the `ln_data_i` and `pk_res_o` equals the `pk_data_i` presented with the strobe.
- R9: Without error, unpack and unpack-all return `pk_res_o` equal to `pk_data_i`, and pack returns `ln_res_o` equal to `ln_data_i`.
- R10: After reset, `res_valid_o` and `res_err_o` are low and both result buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Issue strobe, one cycle |
| op_i | input | 2 | 0 unpack, 1 unpack-all, 2 pack, 3 illegal |
| esz_i | input | 2 | Element width code, 0/1/2 for 8/16/32 bits |
| lane_i | input | 3 | Lane index |
| pk_cnt_i | input | 2 | Packed-side register count |
| ln_cnt_i | input | 3 | Lane-side register count |
| pk_data_i | input | 128 | Packed registers, register 0 in the low 64 bits |
| ln_data_i | input | 256 | Lane registers, register 0 in the low 64 bits |
| res_valid_o | output | 1 | Result valid pulse |
| res_err_o | output | 1 | Illegal operation flag |
| pk_res_o | output | 128 | Packed registers to write back |
| ln_res_o | output | 256 | Lane registers to write back |

## Verification
The hardest case to reach is the interaction of partial update with the limits: a lane index just past the last lane of a 32-bit register, a 32-bit transfer whose lane-side count overflows a single packed register, and the boundary between zero-filled and preserved packed registers. The bench sweeps every operation code, width code, lane index and both counts, including the illegal values, with fresh pseudo-random register contents each time, so each limit is crossed from both sides. After every result it changes the data inputs without a strobe and checks that the outputs do not move.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;
  localparam int REG_W    = 64;
  localparam int LN_REGS  = 4;
  localparam int PK_REGS  = 2;
  localparam int NUM_ESZ  = 3;
  localparam int LN_BUS_W = REG_W * LN_REGS;
  localparam int PK_BUS_W = REG_W * PK_REGS;
  localparam int LANE_W   = $clog2(REG_W / 8);
  localparam int LNC_W    = $clog2(LN_REGS) + 1;
  localparam int PKC_W    = $clog2(PK_REGS) + 1;

  typedef enum logic [1:0] {
    OP_UNPACK     = 2'd0,
    OP_UNPACK_ALL = 2'd1,
    OP_PACK       = 2'd2,
    OP_BAD        = 2'd3
  } shuf_op_e;

  typedef enum logic [1:0] {
    ESZ_8   = 2'd0,
    ESZ_16  = 2'd1,
    ESZ_32  = 2'd2,
    ESZ_BAD = 2'd3
  } shuf_esz_e;
endpackage

// File: rtl/lane_shuffle_decode.sv
module lane_shuffle_decode
  import lane_shuffle_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [1:0]        esz_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [PKC_W-1:0]  pk_cnt_i,
  input  logic [LNC_W-1:0]  ln_cnt_i,
  output logic              err_o
);
  logic lane_bad;
  logic cnt_bad;
  logic cap_bad;
  logic code_bad;
  logic [LNC_W:0] pk_room;

  always_comb begin
    code_bad = (op_i == OP_BAD) || (esz_i == ESZ_BAD);
    // lanes per register shrink as the element widens
    unique case (esz_i)
      ESZ_8:   lane_bad = 1'b0;
      ESZ_16:  lane_bad = (lane_i >= LANE_W'(REG_W / 16));
      ESZ_32:  lane_bad = (lane_i >= LANE_W'(REG_W / 32));
      default: lane_bad = 1'b1;
    endcase
    cnt_bad = (pk_cnt_i == '0) || (pk_cnt_i > PKC_W'(PK_REGS)) ||
              (ln_cnt_i > LNC_W'(LN_REGS)) ||
              ({1'b0, ln_cnt_i} < (LNC_W + 1)'(pk_cnt_i));
    // only 32-bit elements can outgrow the packed side
    pk_room = (LNC_W + 1)'(pk_cnt_i) * (LNC_W + 1)'(REG_W / 32);
    cap_bad = (esz_i == ESZ_32) && ({1'b0, ln_cnt_i} > pk_room);
    err_o   = code_bad || lane_bad || cnt_bad || cap_bad;
  end
endmodule

// File: rtl/lane_shuffle_unpack.sv
module lane_shuffle_unpack
  import lane_shuffle_pkg::*;
#(
  parameter int EW = 8,
  localparam int LANES = REG_W / EW,
  localparam int LB    = $clog2(LANES),
  localparam int SRC_W = LN_REGS * EW
) (
  input  logic                bcast_i,
  input  logic [LB-1:0]       lane_i,
  input  logic [LNC_W-1:0]    cnt_i,
  input  logic [SRC_W-1:0]    src_i,
  input  logic [LN_BUS_W-1:0] old_i,
  output logic [LN_BUS_W-1:0] res_o
);
  for (genvar r = 0; r < LN_REGS; r++) begin : g_reg
    logic reg_on;
    assign reg_on = (cnt_i > LNC_W'(r));
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic hit;
      assign hit = reg_on && (bcast_i || (lane_i == LB'(j)));
      assign res_o[r*REG_W + j*EW +: EW] =
        hit ? src_i[r*EW +: EW] : old_i[r*REG_W + j*EW +: EW];
    end
  end
endmodule

// File: rtl/lane_shuffle_pack.sv
module lane_shuffle_pack
  import lane_shuffle_pkg::*;
#(
  parameter int EW = 8,
  localparam int LANES    = REG_W / EW,
  localparam int LB       = $clog2(LANES),
  localparam int PK_ELEMS = PK_BUS_W / EW
) (
  input  logic [LB-1:0]       lane_i,
  input  logic [LNC_W-1:0]    ln_cnt_i,
  input  logic [PKC_W-1:0]    pk_cnt_i,
  input  logic [LN_BUS_W-1:0] src_i,
  input  logic [PK_BUS_W-1:0] old_i,
  output logic [PK_BUS_W-1:0] res_o
);
  for (genvar k = 0; k < PK_ELEMS; k++) begin : g_elem
    localparam int KREG = (k * EW) / REG_W;
    logic          active;
    logic [EW-1:0] fill;
    assign active = (pk_cnt_i > PKC_W'(KREG));
    if (k < LN_REGS) begin : g_pick
      logic [EW-1:0] lane_v [LANES];
      for (genvar j = 0; j < LANES; j++) begin : g_lv
        assign lane_v[j] = src_i[k*REG_W + j*EW +: EW];
      end
      assign fill = (ln_cnt_i > LNC_W'(k)) ? lane_v[lane_i] : '0;
    end else begin : g_zero
      assign fill = '0;
    end
    assign res_o[k*EW +: EW] = active ? fill : old_i[k*EW +: EW];
  end
endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
  import lane_shuffle_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [1:0]          esz_i,
  input  logic [LANE_W-1:0]   lane_i,
  input  logic [PKC_W-1:0]    pk_cnt_i,
  input  logic [LNC_W-1:0]    ln_cnt_i,
  input  logic [PK_BUS_W-1:0] pk_data_i,
  input  logic [LN_BUS_W-1:0] ln_data_i,
  output logic                res_valid_o,
  output logic                res_err_o,
  output logic [PK_BUS_W-1:0] pk_res_o,
  output logic [LN_BUS_W-1:0] ln_res_o
);
  logic                dec_err;
  logic [LN_BUS_W-1:0] unp_res  [NUM_ESZ];
  logic [PK_BUS_W-1:0] pack_res [NUM_ESZ];
  logic                bcast;

  logic                valid_q;
  logic                err_q,  err_d;
  logic [PK_BUS_W-1:0] pk_q,   pk_d;
  logic [LN_BUS_W-1:0] ln_q,   ln_d;
  logic                cap_en;

  assign bcast = (op_i == OP_UNPACK_ALL);

  lane_shuffle_decode u_dec (
    .op_i     (op_i),
    .esz_i    (esz_i),
    .lane_i   (lane_i),
    .pk_cnt_i (pk_cnt_i),
    .ln_cnt_i (ln_cnt_i),
    .err_o    (dec_err)
  );

  // one datapath per element width, chosen after the fact
  for (genvar w = 0; w < NUM_ESZ; w++) begin : g_width
    localparam int EW = 8 << w;
    localparam int LB = $clog2(REG_W / EW);
    lane_shuffle_unpack #(.EW(EW)) u_unp (
      .bcast_i (bcast),
      .lane_i  (lane_i[LB-1:0]),
      .cnt_i   (ln_cnt_i),
      .src_i   (pk_data_i[LN_REGS*EW-1:0]),
      .old_i   (ln_data_i),
      .res_o   (unp_res[w])
    );
    lane_shuffle_pack #(.EW(EW)) u_pack (
      .lane_i   (lane_i[LB-1:0]),
      .ln_cnt_i (ln_cnt_i),
      .pk_cnt_i (pk_cnt_i),
      .src_i    (ln_data_i),
      .old_i    (pk_data_i),
      .res_o    (pack_res[w])
    );
  end

  // next-state selection
  always_comb begin
    ln_d   = ln_data_i;
    pk_d   = pk_data_i;
    err_d  = dec_err;
    cap_en = start_i;
    if (!dec_err) begin
      unique case (op_i)
        OP_UNPACK, OP_UNPACK_ALL: begin
          unique case (esz_i)
            ESZ_16:  ln_d = unp_res[1];
            ESZ_32:  ln_d = unp_res[2];
            default: ln_d = unp_res[0];
          endcase
        end
        OP_PACK: begin
          unique case (esz_i)
            ESZ_16:  pk_d = pack_res[1];
            ESZ_32:  pk_d = pack_res[2];
            default: pk_d = pack_res[0];
          endcase
        end
        default: ;
      endcase
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      pk_q  <= '0;
      ln_q  <= '0;
    end else if (cap_en) begin
      err_q <= err_d;
      pk_q  <= pk_d;
      ln_q  <= ln_d;
    end
  end

  assign res_valid_o = valid_q;
  assign res_err_o   = err_q;
  assign pk_res_o    = pk_q;
  assign ln_res_o    = ln_q;
endmodule

// File: rtl/lane_shuffle_chk.sv
module lane_shuffle_chk
  import lane_shuffle_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [1:0]          op_i,
  input logic [1:0]          esz_i,
  input logic [LANE_W-1:0]   lane_i,
  input logic [PK_BUS_W-1:0] pk_data_i,
  input logic [LN_BUS_W-1:0] ln_data_i,
  input logic                res_valid_o,
  input logic                res_err_o,
  input logic [PK_BUS_W-1:0] pk_res_o,
  input logic [LN_BUS_W-1:0] ln_res_o
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> res_valid_o);

  assert_valid_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(start_i));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(ln_res_o) && $stable(pk_res_o) && $stable(res_err_o)));

  assert_lane32_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && esz_i == 2'd2 && lane_i >= 3'd2) |=> res_err_o);

  assert_err_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_err_o) |->
      (ln_res_o == $past(ln_data_i) && pk_res_o == $past(pk_data_i)));

  assert_pack_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_err_o && $past(op_i) == 2'd2) |->
      (ln_res_o == $past(ln_data_i)));

  assert_unpack_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_err_o && $past(op_i) != 2'd2) |->
      (pk_res_o == $past(pk_data_i)));
endmodule

bind lane_shuffle lane_shuffle_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .op_i        (op_i),
  .esz_i       (esz_i),
  .lane_i      (lane_i),
  .pk_data_i   (pk_data_i),
  .ln_data_i   (ln_data_i),
  .res_valid_o (res_valid_o),
  .res_err_o   (res_err_o),
  .pk_res_o    (pk_res_o),
  .ln_res_o    (ln_res_o)
);

// File: tb/lane_shuffle_tb.sv
module lane_shuffle_tb;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   op_i;
  logic [1:0]   esz_i;
  logic [2:0]   lane_i;
  logic [1:0]   pk_cnt_i;
  logic [2:0]   ln_cnt_i;
  logic [127:0] pk_data_i;
  logic [255:0] ln_data_i;
  logic         res_valid_o;
  logic         res_err_o;
  logic [127:0] pk_res_o;
  logic [255:0] ln_res_o;

  int n_chk;
  int n_bad;
  logic [63:0] seed;

  logic         x_err;
  logic [127:0] x_pk;
  logic [255:0] x_ln;

  lane_shuffle u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .esz_i       (esz_i),
    .lane_i      (lane_i),
    .pk_cnt_i    (pk_cnt_i),
    .ln_cnt_i    (ln_cnt_i),
    .pk_data_i   (pk_data_i),
    .ln_data_i   (ln_data_i),
    .res_valid_o (res_valid_o),
    .res_err_o   (res_err_o),
    .pk_res_o    (pk_res_o),
    .ln_res_o    (ln_res_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] next_rand(logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic scramble();
    for (int i = 0; i < 2; i++) begin
      seed = next_rand(seed);
      pk_data_i[i*64 +: 64] = seed;
    end
    for (int i = 0; i < 4; i++) begin
      seed = next_rand(seed);
      ln_data_i[i*64 +: 64] = seed;
    end
  endtask

  // expected result from the requirement text
  task automatic model();
    int ew;
    int lanes;
    ew = (esz_i < 2'd3) ? (8 << esz_i) : 8;
    lanes = 64 / ew;
    x_err = (op_i == 2'd3) || (esz_i == 2'd3) || (int'(lane_i) >= lanes) ||
            (pk_cnt_i < 2'd1) || (pk_cnt_i > 2'd2) ||
            (int'(ln_cnt_i) < int'(pk_cnt_i)) || (ln_cnt_i > 3'd4) ||
            (int'(ln_cnt_i) * ew > int'(pk_cnt_i) * 64);
    x_ln = ln_data_i;
    x_pk = pk_data_i;
    if (!x_err) begin
      if (op_i == 2'd0) begin
        for (int i = 0; i < int'(ln_cnt_i); i++)
          for (int b = 0; b < ew; b++)
            x_ln[i*64 + int'(lane_i)*ew + b] = pk_data_i[i*ew + b];
      end else if (op_i == 2'd1) begin
        for (int i = 0; i < int'(ln_cnt_i); i++)
          for (int j = 0; j < lanes; j++)
            for (int b = 0; b < ew; b++)
              x_ln[i*64 + j*ew + b] = pk_data_i[i*ew + b];
      end else begin
        for (int b = 0; b < int'(pk_cnt_i) * 64; b++) x_pk[b] = 1'b0;
        for (int i = 0; i < int'(ln_cnt_i); i++)
          for (int b = 0; b < ew; b++)
            x_pk[i*ew + b] = ln_data_i[i*64 + int'(lane_i)*ew + b];
      end
    end
  endtask

  function automatic string ln_tag();
    if (x_err) return "R8 lane side kept on error";
    if (op_i == 2'd0) return "R2 unpack lane insert (R5 width)";
    if (op_i == 2'd1) return "R3 unpack-all broadcast (R5 width)";
    return "R9 lane side kept by pack";
  endfunction

  function automatic string pk_tag();
    if (x_err) return "R8 packed side kept on error";
    if (op_i == 2'd2) return "R4 pack gather and zero fill (R5 width)";
    return "R9 packed side kept by unpack";
  endfunction

  function automatic string err_tag();
    if (esz_i < 2'd3 && int'(lane_i) >= (64 / (8 << esz_i))) return "R6 lane range";
    return "R7 op, width and count legality";
  endfunction

  task automatic chk1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_pk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d esz=%0d lane=%0d pk=%0d ln=%0d: got %h expected %h",
               tag, op_i, esz_i, lane_i, pk_cnt_i, ln_cnt_i, act, exp);
    end
  endtask

  task automatic chk_ln(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d esz=%0d lane=%0d pk=%0d ln=%0d: got %h expected %h",
               tag, op_i, esz_i, lane_i, pk_cnt_i, ln_cnt_i, act, exp);
    end
  endtask

  task automatic run_one(logic [1:0] op, logic [1:0] esz, logic [2:0] lane,
                         logic [1:0] pkc, logic [2:0] lnc);
    @(negedge clk);
    op_i = op; esz_i = esz; lane_i = lane; pk_cnt_i = pkc; ln_cnt_i = lnc;
    scramble();
    start_i = 1'b1;
    model();
    @(negedge clk);
    start_i = 1'b0;
    chk1("R1 valid after strobe", res_valid_o, 1'b1);
    chk1(err_tag(), res_err_o, x_err);
    chk_ln(ln_tag(), ln_res_o, x_ln);
    chk_pk(pk_tag(), pk_res_o, x_pk);
    scramble();
    @(negedge clk);
    chk1("R1 valid drops", res_valid_o, 1'b0);
    chk_ln("R1 lane result holds", ln_res_o, x_ln);
    chk_pk("R1 packed result holds", pk_res_o, x_pk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    n_chk = 0;
    n_bad = 0;
    seed = 64'h9E37_79B9_7F4A_7C15;
    rst_n = 1'b0;
    start_i = 1'b0;
    op_i = '0; esz_i = '0; lane_i = '0; pk_cnt_i = '0; ln_cnt_i = '0;
    pk_data_i = '0; ln_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R10 reset valid", res_valid_o, 1'b0);
    chk1("R10 reset error", res_err_o, 1'b0);
    chk_ln("R10 reset lane bus", ln_res_o, '0);
    chk_pk("R10 reset packed bus", pk_res_o, '0);
    for (int o = 0; o < 4; o++)
      for (int e = 0; e < 4; e++)
        for (int l = 0; l < 8; l++)
          for (int p = 0; p < 4; p++)
            for (int n = 0; n < 8; n++)
              run_one(2'(o), 2'(e), 3'(l), 2'(p), 3'(n));
    // back-to-back strobes
    @(negedge clk);
    op_i = 2'd1; esz_i = 2'd0; lane_i = 3'd0; pk_cnt_i = 2'd1; ln_cnt_i = 3'd4;
    scramble();
    start_i = 1'b1;
    @(negedge clk);
    op_i = 2'd2; esz_i = 2'd1; lane_i = 3'd3; pk_cnt_i = 2'd2; ln_cnt_i = 3'd3;
    scramble();
    model();
    chk1("R1 valid first of pair", res_valid_o, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    chk1("R1 valid second of pair", res_valid_o, 1'b1);
    chk_pk(pk_tag(), pk_res_o, x_pk);
    @(negedge clk);
    chk1("R1 valid after pair", res_valid_o, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule